// File: doc/BRIEF.md
# Peripheral Address and Interrupt Allocator

This block holds an ordered table of up to `N_ENTRIES` peripheral descriptors. Each descriptor carries an identifier, a requested base address, an address window size, a requested first interrupt line and the number of interrupt lines the peripheral uses. Descriptors are offered one at a time over a valid/ready handshake. A requested value of zero asks the block to choose: it then hands out the next free address window or the next free run of interrupt lines from two running pointers and advances them. A nonzero request is kept as given. Accepted descriptors are appended at the tail, so table position equals arrival order.

The same block routes interrupts. A peripheral names its table position, a local line index and a level. The block translates this into one bit of a global interrupt vector held in registers: the entry's first line plus the local index. A local index at or beyond the entry's own count is rejected. So is a translated line beyond the vector. A one-cycle error flag reports the rejection, and the vector is left as it was.

An init strobe reloads both free pointers from configuration inputs without touching the table. Name strings, address decoding and the interrupt controller itself live elsewhere.

Top module: `palloc_top`

## Requirements
- R1: Once reset has been held (active-low, synchronous), `entry_count` is 0, every `irq_lines` bit is 0, `irq_err` is 0, `reg_ready` is 1, and the free pointers hold `DEF_BASE` and `DEF_IRQ`.
- R2: An accepted descriptor with `reg_base` equal to 0 is stored with base equal to the current `free_base`, and `free_base` advances by `reg_size` at the same edge.
- R3: An accepted descriptor with `reg_irq` equal to 0 and `reg_cnt` greater than 0 is stored with first line equal to the current `free_irq`, and `free_irq` advances by `reg_cnt`. With `reg_cnt` equal to 0 the first line stays 0 and `free_irq` is unchanged.
- R4: A nonzero requested base or first line is stored unchanged, and the matching free pointer does not move.
- R5: A descriptor accepted while `entry_count` is k is stored at position k, and `entry_count` becomes k+1 on the next cycle. The read port at position `rd_idx` returns that descriptor with `rd_valid`=1. A position at or beyond `entry_count` reads `rd_valid`=0 with all fields 0.
- R6: `reg_ready` is low while `entry_count` equals `N_ENTRIES` or while `init_valid` is high. A request made while `reg_ready` is low is not accepted: the table, the count and the pointers are unchanged.
- R7: With `init_valid` high at an edge, `free_base` and `free_irq` take `init_base` and `init_irq` on the next cycle. Table contents are unchanged.
- R8: A routing request (`irq_req_valid`) for entry e with local index k below that entry's count sets global line (first line of e + k) to `irq_req_level` on the next cycle, provided that line is below `NUM_LINES`. No other line changes.
- R9: A routing request whose k is at or above the entry's count is rejected. This includes an entry position not yet filled, whose count reads as 0. A request whose translated line is at or above `NUM_LINES` is also rejected. On rejection `irq_lines` is unchanged and `irq_err` is 1 on the next cycle.
- R10: `irq_err` is 1 only in the cycle right after a rejected request. It is 0 after accepted requests and when no request is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| init_valid | input | 1 | Reload the free pointers |
| init_base | input | ADDR_W | New free-base pointer |
| init_irq | input | IRQ_W | New free-interrupt pointer |
| reg_valid | input | 1 | Descriptor offered |
| reg_ready | output | 1 | Descriptor can be accepted this cycle |
| reg_id | input | ID_W | Descriptor identifier |
| reg_base | input | ADDR_W | Requested base address, 0 = choose |
| reg_size | input | ADDR_W | Address window size |
| reg_irq | input | IRQ_W | Requested first line, 0 = choose |
| reg_cnt | input | CNT_W | Number of interrupt lines |
| entry_count | output | CNTE_W | Number of stored descriptors |
| free_base | output | ADDR_W | Next address handed out |
| free_irq | output | IRQ_W | Next interrupt line handed out |
| rd_idx | input | IDX_W | Table position to read |
| rd_valid | output | 1 | Position holds a descriptor |
| rd_id | output | ID_W | Stored identifier |
| rd_base | output | ADDR_W | Stored base |
| rd_size | output | ADDR_W | Stored size |
| rd_irq | output | IRQ_W | Stored first line |
| rd_cnt | output | CNT_W | Stored line count |
| irq_req_valid | input | 1 | Routing request |
| irq_req_entry | input | IDX_W | Table position of the requester |
| irq_req_local | input | CNT_W | Local line index |
| irq_req_level | input | 1 | Level to drive |
| irq_lines | output | NUM_LINES | Global interrupt vector |
| irq_err | output | 1 | Previous request rejected |

## Verification
Allocation is tried with four descriptor kinds: both values left to the block, both requested, a zero line count with an automatic line, and a plain automatic descriptor. Together they show whether each pointer moves only when its own value is chosen automatically. Descriptors are offered into a full table and alongside an init strobe, which shows whether the ready gating really blocks them. Routing is tried with an in-range index, an index equal to the count, a request from an empty position, a translated line past the top of the vector and a level clear. These separate a correct bounds check from one that is off by one or compares against the wrong count.

// File: rtl/palloc_pkg.sv
// Shared definitions for the peripheral allocator.
// Assumes: nothing beyond IEEE 1800-2017.
package palloc_pkg;

    // Outcome of a routing request in the current cycle.
    typedef enum logic [1:0] {
        RT_NONE   = 2'd0,
        RT_DRIVE  = 2'd1,
        RT_REJECT = 2'd2
    } route_e;

endpackage

// File: rtl/palloc_ptrs.sv
// Free-pointer unit: decides the base and first line for an incoming
// descriptor and advances the running pointers when a value is chosen
// automatically. Assumes CNT_W <= IRQ_W, and that init and an accepted
// descriptor never occur in the same cycle (the top blocks ready).
module palloc_ptrs #(
    parameter int ADDR_W = 32,
    parameter int IRQ_W  = 5,
    parameter int CNT_W  = 4,
    parameter logic [ADDR_W-1:0] DEF_BASE = '0,
    parameter int DEF_IRQ = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init_valid,
    input  logic [ADDR_W-1:0] init_base,
    input  logic [IRQ_W-1:0]  init_irq,
    input  logic              take,
    input  logic [ADDR_W-1:0] req_base,
    input  logic [ADDR_W-1:0] req_size,
    input  logic [IRQ_W-1:0]  req_irq,
    input  logic [CNT_W-1:0]  req_cnt,
    output logic [ADDR_W-1:0] asg_base,
    output logic [IRQ_W-1:0]  asg_irq,
    output logic [ADDR_W-1:0] free_base,
    output logic [IRQ_W-1:0]  free_irq
);

    logic auto_base;
    logic auto_irq;

    // Pick requested or automatic values for the descriptor on the inputs.
    always_comb begin
        auto_base = (req_base == '0);
        auto_irq  = (req_irq == '0) && (req_cnt != '0);
        asg_base  = auto_base ? free_base : req_base;
        asg_irq   = auto_irq  ? free_irq  : req_irq;
    end

    // Running pointers: reset, reload on init, advance on automatic choice.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            free_base <= DEF_BASE;
            free_irq  <= IRQ_W'(DEF_IRQ);
        end else if (init_valid) begin
            free_base <= init_base;
            free_irq  <= init_irq;
        end else if (take) begin
            if (auto_base) free_base <= free_base + req_size;
            if (auto_irq)  free_irq  <= free_irq + IRQ_W'(req_cnt);
        end
    end

endmodule

// File: rtl/palloc_table.sv
// Descriptor table: append-only storage in arrival order with one read
// port for software-side inspection and one for the interrupt router.
// Positions at or beyond the fill count read as all zeros.
// Assumes the writer only asserts wr_en when full is low.
module palloc_table #(
    parameter int N_ENTRIES = 4,
    parameter int ADDR_W    = 32,
    parameter int ID_W      = 8,
    parameter int IRQ_W     = 5,
    parameter int CNT_W     = 4,
    localparam int IDX_W    = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1,
    localparam int CNTE_W   = $clog2(N_ENTRIES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ID_W-1:0]   wr_id,
    input  logic [ADDR_W-1:0] wr_base,
    input  logic [ADDR_W-1:0] wr_size,
    input  logic [IRQ_W-1:0]  wr_irq,
    input  logic [CNT_W-1:0]  wr_cnt,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [IDX_W-1:0]  rt_idx,
    output logic [CNTE_W-1:0] count,
    output logic              full,
    output logic              rd_valid,
    output logic [ID_W-1:0]   rd_id,
    output logic [ADDR_W-1:0] rd_base,
    output logic [ADDR_W-1:0] rd_size,
    output logic [IRQ_W-1:0]  rd_irq,
    output logic [CNT_W-1:0]  rd_cnt,
    output logic [IRQ_W-1:0]  rt_irq,
    output logic [CNT_W-1:0]  rt_cnt
);

    logic [ID_W-1:0]   ids   [N_ENTRIES];
    logic [ADDR_W-1:0] bases [N_ENTRIES];
    logic [ADDR_W-1:0] sizes [N_ENTRIES];
    logic [IRQ_W-1:0]  irqs  [N_ENTRIES];
    logic [CNT_W-1:0]  cnts  [N_ENTRIES];

    assign full = (int'(count) >= N_ENTRIES);

    // Fill count: grows by one per appended descriptor.
    always_ff @(posedge clk) begin
        if (!rst_n)                count <= '0;
        else if (wr_en && !full)   count <= count + 1'b1;
    end

    // One storage slot per position; only the tail slot is written.
    for (genvar i = 0; i < N_ENTRIES; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ids[i]   <= '0;
                bases[i] <= '0;
                sizes[i] <= '0;
                irqs[i]  <= '0;
                cnts[i]  <= '0;
            end else if (wr_en && !full && (int'(count) == i)) begin
                ids[i]   <= wr_id;
                bases[i] <= wr_base;
                sizes[i] <= wr_size;
                irqs[i]  <= wr_irq;
                cnts[i]  <= wr_cnt;
            end
        end
    end

    // Inspection port: masked to zero outside the filled range.
    always_comb begin
        rd_valid = (int'(rd_idx) < int'(count));
        rd_id    = rd_valid ? ids[rd_idx]   : '0;
        rd_base  = rd_valid ? bases[rd_idx] : '0;
        rd_size  = rd_valid ? sizes[rd_idx] : '0;
        rd_irq   = rd_valid ? irqs[rd_idx]  : '0;
        rd_cnt   = rd_valid ? cnts[rd_idx]  : '0;
    end

    // Router port: an empty position reports a count of zero.
    always_comb begin
        if (int'(rt_idx) < int'(count)) begin
            rt_irq = irqs[rt_idx];
            rt_cnt = cnts[rt_idx];
        end else begin
            rt_irq = '0;
            rt_cnt = '0;
        end
    end

endmodule

// File: rtl/palloc_router.sv
// Interrupt router: translates (first line + local index) into one bit of
// a registered global vector, rejecting indices outside the entry's count
// or past the top of the vector, and flags a rejection for one cycle.
// Assumes ent_first/ent_cnt are already the requester's table values.
module palloc_router
    import palloc_pkg::*;
#(
    parameter int NUM_LINES = 32,
    parameter int IRQ_W     = 5,
    parameter int CNT_W     = 4,
    localparam int SUM_W    = ((IRQ_W > CNT_W) ? IRQ_W : CNT_W) + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [CNT_W-1:0]     req_local,
    input  logic                 req_level,
    input  logic [IRQ_W-1:0]     ent_first,
    input  logic [CNT_W-1:0]     ent_cnt,
    output logic [NUM_LINES-1:0] lines,
    output logic                 err
);

    logic [SUM_W-1:0] target;
    route_e           outcome;

    // Classify the request and compute the global line it names.
    always_comb begin
        target = SUM_W'(ent_first) + SUM_W'(req_local);
        if (!req_valid)
            outcome = RT_NONE;
        else if ((req_local >= ent_cnt) || (int'(target) >= NUM_LINES))
            outcome = RT_REJECT;
        else
            outcome = RT_DRIVE;
    end

    // One register per global line, written only when it is the target.
    for (genvar j = 0; j < NUM_LINES; j++) begin : g_line
        always_ff @(posedge clk) begin
            if (!rst_n)
                lines[j] <= 1'b0;
            else if ((outcome == RT_DRIVE) && (int'(target) == j))
                lines[j] <= req_level;
        end
    end

    // Rejection flag, high for exactly the cycle after a bad request.
    always_ff @(posedge clk) begin
        if (!rst_n) err <= 1'b0;
        else        err <= (outcome == RT_REJECT);
    end

endmodule

// File: rtl/palloc_top.sv
// Peripheral allocator top: accepts descriptors over valid/ready, assigns
// address windows and interrupt runs where zero was requested, keeps them
// in arrival order, and routes local interrupt requests to a global vector.
// Assumes NUM_LINES is a power of two and CNT_W <= IRQ_W.
module palloc_top #(
    parameter int N_ENTRIES = 4,
    parameter int ADDR_W    = 32,
    parameter int ID_W      = 8,
    parameter int NUM_LINES = 32,
    parameter int CNT_W     = 4,
    parameter logic [ADDR_W-1:0] DEF_BASE = 32'h1000_0000,
    parameter int DEF_IRQ   = 1,
    localparam int IRQ_W    = $clog2(NUM_LINES),
    localparam int IDX_W    = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1,
    localparam int CNTE_W   = $clog2(N_ENTRIES + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 init_valid,
    input  logic [ADDR_W-1:0]    init_base,
    input  logic [IRQ_W-1:0]     init_irq,
    input  logic                 reg_valid,
    output logic                 reg_ready,
    input  logic [ID_W-1:0]      reg_id,
    input  logic [ADDR_W-1:0]    reg_base,
    input  logic [ADDR_W-1:0]    reg_size,
    input  logic [IRQ_W-1:0]     reg_irq,
    input  logic [CNT_W-1:0]     reg_cnt,
    output logic [CNTE_W-1:0]    entry_count,
    output logic [ADDR_W-1:0]    free_base,
    output logic [IRQ_W-1:0]     free_irq,
    input  logic [IDX_W-1:0]     rd_idx,
    output logic                 rd_valid,
    output logic [ID_W-1:0]      rd_id,
    output logic [ADDR_W-1:0]    rd_base,
    output logic [ADDR_W-1:0]    rd_size,
    output logic [IRQ_W-1:0]     rd_irq,
    output logic [CNT_W-1:0]     rd_cnt,
    input  logic                 irq_req_valid,
    input  logic [IDX_W-1:0]     irq_req_entry,
    input  logic [CNT_W-1:0]     irq_req_local,
    input  logic                 irq_req_level,
    output logic [NUM_LINES-1:0] irq_lines,
    output logic                 irq_err
);

    logic              tbl_full;
    logic              take;
    logic [ADDR_W-1:0] asg_base;
    logic [IRQ_W-1:0]  asg_irq;
    logic [IRQ_W-1:0]  rt_irq;
    logic [CNT_W-1:0]  rt_cnt;

    // Handshake: blocked while full or while the pointers are being reloaded.
    assign reg_ready = !tbl_full && !init_valid;
    assign take      = reg_valid && reg_ready;

    palloc_ptrs #(
        .ADDR_W   (ADDR_W),
        .IRQ_W    (IRQ_W),
        .CNT_W    (CNT_W),
        .DEF_BASE (DEF_BASE),
        .DEF_IRQ  (DEF_IRQ)
    ) u_ptrs (
        .clk        (clk),
        .rst_n      (rst_n),
        .init_valid (init_valid),
        .init_base  (init_base),
        .init_irq   (init_irq),
        .take       (take),
        .req_base   (reg_base),
        .req_size   (reg_size),
        .req_irq    (reg_irq),
        .req_cnt    (reg_cnt),
        .asg_base   (asg_base),
        .asg_irq    (asg_irq),
        .free_base  (free_base),
        .free_irq   (free_irq)
    );

    palloc_table #(
        .N_ENTRIES (N_ENTRIES),
        .ADDR_W    (ADDR_W),
        .ID_W      (ID_W),
        .IRQ_W     (IRQ_W),
        .CNT_W     (CNT_W)
    ) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (take),
        .wr_id    (reg_id),
        .wr_base  (asg_base),
        .wr_size  (reg_size),
        .wr_irq   (asg_irq),
        .wr_cnt   (reg_cnt),
        .rd_idx   (rd_idx),
        .rt_idx   (irq_req_entry),
        .count    (entry_count),
        .full     (tbl_full),
        .rd_valid (rd_valid),
        .rd_id    (rd_id),
        .rd_base  (rd_base),
        .rd_size  (rd_size),
        .rd_irq   (rd_irq),
        .rd_cnt   (rd_cnt),
        .rt_irq   (rt_irq),
        .rt_cnt   (rt_cnt)
    );

    palloc_router #(
        .NUM_LINES (NUM_LINES),
        .IRQ_W     (IRQ_W),
        .CNT_W     (CNT_W)
    ) u_router (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (irq_req_valid),
        .req_local (irq_req_local),
        .req_level (irq_req_level),
        .ent_first (rt_irq),
        .ent_cnt   (rt_cnt),
        .lines     (irq_lines),
        .err       (irq_err)
    );

endmodule

// File: rtl/palloc_chk.sv
// Protocol and state checks for palloc_top, attached by bind.
// Assumes the same parameter values as the instance it is bound to.
module palloc_chk #(
    parameter int N_ENTRIES = 4,
    parameter int ADDR_W    = 32,
    parameter int NUM_LINES = 32,
    localparam int CNTE_W   = $clog2(N_ENTRIES + 1)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 init_valid,
    input logic [ADDR_W-1:0]    init_base,
    input logic                 reg_valid,
    input logic                 reg_ready,
    input logic [CNTE_W-1:0]    entry_count,
    input logic [ADDR_W-1:0]    free_base,
    input logic                 irq_req_valid,
    input logic [NUM_LINES-1:0] irq_lines,
    input logic                 irq_err
);

    p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (entry_count == '0 && irq_lines == '0 && !irq_err));

    p_append_grows_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_valid && reg_ready) |=> (entry_count == $past(entry_count) + 1'b1));

    p_count_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        int'(entry_count) <= N_ENTRIES);

    p_full_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(entry_count) == N_ENTRIES) |-> !reg_ready);

    p_no_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_valid && reg_ready) |=> $stable(entry_count));

    p_init_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        init_valid |=> (free_base == $past(init_base)));

    p_quiet_lines_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(irq_req_valid) |-> $stable(irq_lines));

    p_reject_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_err |-> $stable(irq_lines));

    p_err_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(irq_req_valid) |-> !irq_err);

endmodule

bind palloc_top palloc_chk #(
    .N_ENTRIES (N_ENTRIES),
    .ADDR_W    (ADDR_W),
    .NUM_LINES (NUM_LINES)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .init_valid    (init_valid),
    .init_base     (init_base),
    .reg_valid     (reg_valid),
    .reg_ready     (reg_ready),
    .entry_count   (entry_count),
    .free_base     (free_base),
    .irq_req_valid (irq_req_valid),
    .irq_lines     (irq_lines),
    .irq_err       (irq_err)
);

// File: tb/palloc_top_test.sv
`timescale 1ns/1ps
module palloc_top_test;

    localparam int N = 4;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        init_valid = 0;
    logic [31:0] init_base = '0;
    logic [4:0]  init_irq = '0;
    logic        reg_valid = 0;
    logic        reg_ready;
    logic [7:0]  reg_id = '0;
    logic [31:0] reg_base = '0;
    logic [31:0] reg_size = '0;
    logic [4:0]  reg_irq = '0;
    logic [3:0]  reg_cnt = '0;
    logic [2:0]  entry_count;
    logic [31:0] free_base;
    logic [4:0]  free_irq;
    logic [1:0]  rd_idx = '0;
    logic        rd_valid;
    logic [7:0]  rd_id;
    logic [31:0] rd_base;
    logic [31:0] rd_size;
    logic [4:0]  rd_irq;
    logic [3:0]  rd_cnt;
    logic        irq_req_valid = 0;
    logic [1:0]  irq_req_entry = '0;
    logic [3:0]  irq_req_local = '0;
    logic        irq_req_level = 0;
    logic [31:0] irq_lines;
    logic        irq_err;

    palloc_top uut (.*);

    always #4 clk = ~clk;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;
    bit started = 0;

    // Behavioural reference state.
    int          m_cnt;
    logic [31:0] m_fb;
    logic [4:0]  m_fi;
    logic [31:0] m_lines;
    bit          m_err;
    logic [7:0]  m_id   [N];
    logic [31:0] m_base [N];
    logic [31:0] m_size [N];
    logic [4:0]  m_irq  [N];
    logic [3:0]  m_ic   [N];

    task automatic ceq(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Reference model update at each edge, from the inputs only.
    always @(posedge clk) begin
        started = 1;
        if (!rst_n) begin
            m_cnt = 0; m_fb = 32'h1000_0000; m_fi = 5'd1; m_lines = '0; m_err = 0;
            for (int i = 0; i < N; i++) begin
                m_id[i] = 0; m_base[i] = 0; m_size[i] = 0; m_irq[i] = 0; m_ic[i] = 0;
            end
        end else begin
            int e, c, f, t;
            bit bad;
            bad = 0;
            if (irq_req_valid) begin
                e = int'(irq_req_entry);
                c = (e < m_cnt) ? int'(m_ic[e]) : 0;
                f = (e < m_cnt) ? int'(m_irq[e]) : 0;
                t = f + int'(irq_req_local);
                if (int'(irq_req_local) >= c || t >= 32) bad = 1;
                else m_lines[t] = irq_req_level;
            end
            m_err = bad;
            if (init_valid) begin
                m_fb = init_base; m_fi = init_irq;
            end else if (reg_valid && m_cnt < N) begin
                m_id[m_cnt] = reg_id; m_size[m_cnt] = reg_size; m_ic[m_cnt] = reg_cnt;
                if (reg_base == 0) begin m_base[m_cnt] = m_fb; m_fb = m_fb + reg_size; end
                else m_base[m_cnt] = reg_base;
                if (reg_irq == 0 && reg_cnt != 0) begin m_irq[m_cnt] = m_fi; m_fi = m_fi + 5'(reg_cnt); end
                else m_irq[m_cnt] = reg_irq;
                m_cnt++;
            end
        end
    end

    // Cycle-by-cycle comparison away from the active edge.
    always @(negedge clk) begin
        if (started && !done) begin
            int r;
            bit v;
            r = int'(rd_idx);
            v = r < m_cnt;
            ceq("R5 entry_count", 64'(entry_count), 64'(m_cnt));
            ceq("R2 free_base", 64'(free_base), 64'(m_fb));
            ceq("R3 free_irq", 64'(free_irq), 64'(m_fi));
            ceq("R6 reg_ready", 64'(reg_ready), 64'(m_cnt < N && !init_valid));
            ceq("R8 irq_lines", 64'(irq_lines), 64'(m_lines));
            ceq("R9 irq_err", 64'(irq_err), 64'(m_err));
            ceq("R5 rd_valid", 64'(rd_valid), 64'(v));
            ceq("R5 rd_id", 64'(rd_id), v ? 64'(m_id[r]) : 64'd0);
            ceq("R2 rd_base", 64'(rd_base), v ? 64'(m_base[r]) : 64'd0);
            ceq("R5 rd_size", 64'(rd_size), v ? 64'(m_size[r]) : 64'd0);
            ceq("R3 rd_irq", 64'(rd_irq), v ? 64'(m_irq[r]) : 64'd0);
            ceq("R5 rd_cnt", 64'(rd_cnt), v ? 64'(m_ic[r]) : 64'd0);
        end
    end

    // Sweep the read port so every position is compared in turn.
    always @(posedge clk) #1 rd_idx <= rd_idx + 1'b1;

    task automatic do_reset();
        @(posedge clk); #1 rst_n = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
    endtask

    task automatic do_reg(input logic [7:0] id, input logic [31:0] b, input logic [31:0] s,
                          input logic [4:0] q, input logic [3:0] c);
        @(posedge clk); #1;
        reg_valid = 1; reg_id = id; reg_base = b; reg_size = s; reg_irq = q; reg_cnt = c;
        @(posedge clk); #1 reg_valid = 0;
    endtask

    task automatic do_init(input logic [31:0] b, input logic [4:0] q);
        @(posedge clk); #1 init_valid = 1; init_base = b; init_irq = q;
        @(posedge clk); #1 init_valid = 0;
    endtask

    task automatic do_irq(input logic [1:0] e, input logic [3:0] k, input logic lvl);
        @(posedge clk); #1 irq_req_valid = 1; irq_req_entry = e; irq_req_local = k; irq_req_level = lvl;
        @(posedge clk); #1 irq_req_valid = 0;
    endtask

    // Read one table position through the port, between sweeps.
    task automatic peek(input logic [1:0] p);
        @(posedge clk); #2 rd_idx = p;
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            done = 1;
            n_tests++; n_fail++;
            $display("FAIL watchdog expired actual=hung expected=finish");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        do_reset();
        @(negedge clk);
        ceq("R1 count after reset", 64'(entry_count), 0);
        ceq("R1 lines after reset", 64'(irq_lines), 0);
        ceq("R1 base pointer after reset", 64'(free_base), 64'h1000_0000);
        ceq("R1 irq pointer after reset", 64'(free_irq), 1);
        ceq("R1 ready after reset", 64'(reg_ready), 1);

        do_init(32'h2000_0000, 5'd4);
        @(negedge clk);
        ceq("R7 init base", 64'(free_base), 64'h2000_0000);
        ceq("R7 init irq", 64'(free_irq), 4);

        do_reg(8'h01, 32'h0, 32'h1000, 5'd0, 4'd2);
        @(negedge clk);
        ceq("R2 auto base advance", 64'(free_base), 64'h2000_1000);
        ceq("R3 auto irq advance", 64'(free_irq), 6);

        do_reg(8'h02, 32'h3000_0000, 32'h800, 5'd10, 4'd3);
        @(negedge clk);
        ceq("R4 requested base keeps pointer", 64'(free_base), 64'h2000_1000);
        ceq("R4 requested irq keeps pointer", 64'(free_irq), 6);

        do_reg(8'h03, 32'h0, 32'h400, 5'd0, 4'd0);
        @(negedge clk);
        ceq("R3 zero count keeps irq pointer", 64'(free_irq), 6);
        ceq("R2 base advance entry 2", 64'(free_base), 64'h2000_1400);

        do_reg(8'h04, 32'h0, 32'h100, 5'd0, 4'd4);
        peek(2'd3);
        @(negedge clk);
        ceq("R5 tail entry id", 64'(rd_id), 4);
        ceq("R2 tail entry base", 64'(rd_base), 64'h2000_1400);
        ceq("R3 tail entry irq", 64'(rd_irq), 6);
        peek(2'd1);
        @(negedge clk);
        ceq("R4 requested base stored", 64'(rd_base), 64'h3000_0000);
        ceq("R4 requested irq stored", 64'(rd_irq), 10);

        do_reg(8'h05, 32'h0, 32'h100, 5'd0, 4'd1);
        @(negedge clk);
        ceq("R6 full keeps count", 64'(entry_count), 4);
        ceq("R6 full keeps base pointer", 64'(free_base), 64'h2000_1500);
        ceq("R6 full not ready", 64'(reg_ready), 0);

        do_irq(2'd0, 4'd1, 1'b1);
        do_irq(2'd1, 4'd2, 1'b1);
        do_irq(2'd0, 4'd2, 1'b1);
        @(negedge clk);
        ceq("R9 index equal to count rejected", 64'(irq_err), 1);
        ceq("R9 lines unchanged on reject", 64'(irq_lines), 64'h0000_1020);
        do_irq(2'd2, 4'd0, 1'b1);
        @(negedge clk);
        ceq("R9 zero count entry rejected", 64'(irq_err), 1);
        do_irq(2'd3, 4'd3, 1'b1);
        do_irq(2'd0, 4'd1, 1'b0);
        @(negedge clk);
        ceq("R8 routed lines", 64'(irq_lines), 64'h0000_1200);
        ceq("R10 no error on good request", 64'(irq_err), 0);
        @(negedge clk);
        ceq("R10 error stays low", 64'(irq_err), 0);

        do_reset();
        do_reg(8'h09, 32'h100, 32'h10, 5'd30, 4'd4);
        do_irq(2'd0, 4'd2, 1'b1);
        @(negedge clk);
        ceq("R9 line past vector rejected", 64'(irq_err), 1);
        do_irq(2'd1, 4'd0, 1'b1);
        @(negedge clk);
        ceq("R9 empty position rejected", 64'(irq_err), 1);
        do_irq(2'd0, 4'd1, 1'b1);
        @(negedge clk);
        ceq("R8 top line set", 64'(irq_lines), 64'h8000_0000);

        @(posedge clk); #1 init_valid = 1; reg_valid = 1; reg_id = 8'h0a;
        reg_base = 0; reg_size = 32'h40; reg_irq = 0; reg_cnt = 4'd1;
        init_base = 32'h4000_0000; init_irq = 5'd2;
        @(negedge clk);
        ceq("R6 init blocks ready", 64'(reg_ready), 0);
        @(posedge clk); #1 init_valid = 0; reg_valid = 0;
        @(negedge clk);
        ceq("R7 table unchanged by init", 64'(entry_count), 1);
        ceq("R7 base reloaded", 64'(free_base), 64'h4000_0000);

        repeat (4) @(posedge clk);
        @(negedge clk);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule